// File: doc/BRIEF.md
# Line Period Measurement Timer

This block measures the period of the mains voltage. It counts ticks of a 256 kHz timebase between two successive rising zero crossings of one selected phase. Each phase arrives as the sign bit of a filtered, signed voltage sample, valid on a shared sample strobe. A select input picks the phase that is timed.

Once per line cycle the block publishes a 16-bit unsigned period, with one LSB equal to 3.90625 µs. A 50 Hz line reads about 5120 and a 60 Hz line about 4267. A one-cycle pulse marks each refresh, and the value is held until the next refresh. Very slow lines, below about 3.9 Hz, clamp to the largest code and do not wrap. Dividing the result into a frequency is left to the consumer.

Top module: `line_period_timer`

## Requirements
- R1: While reset is asserted and after its release, `period_o` is 0 and `period_upd_o` is 0 until the first published period.
- R2: The published period equals the number of clock cycles with `tick_en_i` high counted from the cycle after the previous crossing up to and including the crossing cycle. It appears on `period_o`, together with `period_upd_o` high, in the cycle after the crossing edge.
- R3: A crossing is a strobe (`smp_stb_i` high) that samples the selected sign as 0 (non-negative) when the previous strobe sampled it as 1 (negative). Sign values in cycles without a strobe are ignored.
- R4: The first crossing after reset or after a restart only arms the timer. It produces no update pulse.
- R5: If the running count reaches 0xFFFF before the next crossing, it stays at 0xFFFF, and that crossing publishes 0xFFFF.
- R6: `period_o` changes only in a cycle where `period_upd_o` is high.
- R7: Any change of `phase_sel_i` restarts the measurement. A crossing in the same cycle as the change is ignored, and the next update comes only after a complete period on the new phase.
- R8: Phase select code 0 picks phase A (`phase_neg_i[0]`), 1 picks B, and 2 picks C. Code 3 picks no phase: no update is issued and `period_o` keeps its value.
- R9: `period_upd_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | 256 kHz timebase tick, one clock wide |
| smp_stb_i | input | 1 | Sample strobe qualifying the sign bits |
| phase_neg_i | input | 3 | Sign of each phase sample (1 = negative), bit 0 is phase A |
| phase_sel_i | input | 2 | Phase select (0 = A, 1 = B, 2 = C, 3 = none) |
| period_o | output | 16 | Last measured line period in ticks |
| period_upd_o | output | 1 | One-cycle pulse when period_o is refreshed |

## Verification
A timebase tick can land in the same cycle as a detected crossing. That tick must be charged to the period that is closing and not to the one that starts. Most waveforms drive the tick in every cycle, so every crossing coincides with a tick, and one waveform ticks only on alternate cycles. An exact expected count (5120, 4267, 600, 200, 100) is computed for each case. A second collision is a select change landing on a cycle that would otherwise be a crossing. The bench builds that case on purpose and checks that no pulse follows and that exactly one period is needed before the next update.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

   // Measurement state of the period timer
   typedef enum logic [1:0] {
      LPT_IDLE = 2'd0,   // no valid phase selected
      LPT_SEEK = 2'd1,   // waiting for the arming crossing
      LPT_RUN  = 2'd2    // counting a full period
   } lpt_state_e;

   localparam int unsigned LPT_CNT_W_DEFAULT = 16;
   localparam int unsigned LPT_NUM_PH_DEFAULT = 3;

endpackage

// File: rtl/lpt_phase_mux.sv
module lpt_phase_mux #(
   parameter int unsigned N_PH  = 3,
   parameter int unsigned SEL_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  sel_i,
   input  logic [N_PH-1:0]   neg_i,
   output logic              sign_o,
   output logic              valid_o,
   output logic              restart_o
);

   localparam int unsigned SEL_CODES = 1 << SEL_W;

   logic [SEL_W-1:0] sel_q;

   always_comb begin
      sign_o = 1'b0;
      for (int k = 0; k < int'(N_PH); k++) begin
         if (int'(sel_i) == k) sign_o = neg_i[k];
      end
   end

   generate
      if (SEL_CODES == N_PH) begin : g_full
         assign valid_o = 1'b1;
      end else begin : g_partial
         assign valid_o = (int'(sel_i) < int'(N_PH));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= '0;
      else        sel_q <= sel_i;
   end

   assign restart_o = (sel_i != sel_q);

endmodule

// File: rtl/lpt_edge_det.sv
module lpt_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_i,
   input  logic neg_i,
   input  logic clr_i,
   output logic xing_o
);

   logic prev_neg_q;
   logic prev_ok_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_neg_q <= 1'b0;
         prev_ok_q  <= 1'b0;
      end else if (clr_i) begin
         prev_ok_q  <= 1'b0;
      end else if (stb_i) begin
         prev_neg_q <= neg_i;
         prev_ok_q  <= 1'b1;
      end
   end

   assign xing_o = stb_i && prev_ok_q && prev_neg_q && !neg_i && !clr_i;

   // R3: a crossing is only ever seen on a strobe after a negative sample
   assert_xing_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      xing_o |-> (stb_i && prev_neg_q));

endmodule

// File: rtl/lpt_sat_counter.sv
module lpt_sat_counter #(
   parameter int unsigned W        = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         inc_i,
   output logic [W-1:0] cnt_o,
   output logic [W-1:0] cnt_next_o
);

   localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

   logic [W-1:0] cnt_q;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_next_o = (inc_i && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
      end else begin : g_wrap
         assign cnt_next_o = cnt_q + {{(W-1){1'b0}}, inc_i};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt_q <= '0;
      else if (clr_i) cnt_q <= '0;
      else            cnt_q <= cnt_next_o;
   end

   assign cnt_o = cnt_q;

   generate
      if (SATURATE) begin : g_sat_chk
         // R5: once full, the count holds until cleared
         assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));
      end
   endgenerate

endmodule

// File: rtl/line_period_timer.sv
module line_period_timer
   import lpt_pkg::*;
#(
   parameter int unsigned CNT_W    = LPT_CNT_W_DEFAULT,
   parameter int unsigned N_PH     = LPT_NUM_PH_DEFAULT,
   parameter int unsigned SEL_W    = 2,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en_i,
   input  logic             smp_stb_i,
   input  logic [N_PH-1:0]  phase_neg_i,
   input  logic [SEL_W-1:0] phase_sel_i,
   output logic [CNT_W-1:0] period_o,
   output logic             period_upd_o
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("line_period_timer: CNT_W out of range");
      end
      if ((1 << SEL_W) < N_PH || N_PH < 1) begin : g_bad_sel
         $error("line_period_timer: SEL_W too narrow for N_PH");
      end
   endgenerate

   logic             sel_sign;
   logic             sel_valid;
   logic             sel_restart;
   logic             clr_all;
   logic             xing;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_next;
   lpt_state_e       state_q;
   logic [CNT_W-1:0] period_q;
   logic             upd_q;

   lpt_phase_mux #(.N_PH(N_PH), .SEL_W(SEL_W)) u_mux (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel_i     (phase_sel_i),
      .neg_i     (phase_neg_i),
      .sign_o    (sel_sign),
      .valid_o   (sel_valid),
      .restart_o (sel_restart)
   );

   assign clr_all = sel_restart || !sel_valid;

   lpt_edge_det u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb_i  (smp_stb_i),
      .neg_i  (sel_sign),
      .clr_i  (clr_all),
      .xing_o (xing)
   );

   lpt_sat_counter #(.W(CNT_W), .SATURATE(SATURATE)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr_all || xing),
      .inc_i      (tick_en_i && state_q == LPT_RUN),
      .cnt_o      (cnt),
      .cnt_next_o (cnt_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= LPT_SEEK;
      end else if (!sel_valid) begin
         state_q <= LPT_IDLE;
      end else if (sel_restart) begin
         state_q <= LPT_SEEK;
      end else if (xing) begin
         state_q <= LPT_RUN;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q <= '0;
         upd_q    <= 1'b0;
      end else begin
         upd_q <= xing && state_q == LPT_RUN;
         if (xing && state_q == LPT_RUN) period_q <= cnt_next;
      end
   end

   assign period_o     = period_q;
   assign period_upd_o = upd_q;

   // R4: the arming crossing publishes nothing
   assert_arm_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (xing && state_q == LPT_SEEK) |=> !period_upd_o);

   // R6: the output holds between updates
   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !period_upd_o |-> $stable(period_o));

   // R7: a select change suppresses the next pulse
   assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sel_restart |=> !period_upd_o);

   // R8: with no valid phase nothing is published
   assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_valid |=> !period_upd_o);

   // R9: the update is a single-cycle pulse
   assert_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      period_upd_o |=> !period_upd_o);

   // R2: while running, the count never exceeds the value it publishes
   assert_count_track_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (xing && state_q == LPT_RUN) |=> (period_o >= $past(cnt)));

endmodule

// File: tb/line_period_timer_tb.sv
module line_period_timer_tb;

   localparam int CLK_PERIOD = 10;
   localparam int MAXV = 65535;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en_i = 1'b0;
   logic        smp_stb_i = 1'b0;
   logic [2:0]  phase_neg_i = 3'b000;
   logic [1:0]  phase_sel_i = 2'd0;
   logic [15:0] period_o;
   logic        period_upd_o;

   int n_checks = 0;
   int n_fail   = 0;
   int gcnt     = 0;
   int upd_seen = 0;
   int last_per = 0;
   string tag   = "R2";

   // reference model state
   int m_prev_neg = 0, m_prev_ok = 0, m_armed = 0, m_cnt = 0;
   int m_per = 0, m_upd = 0, m_sel_q = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   line_period_timer u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick_en_i    (tick_en_i),
      .smp_stb_i    (smp_stb_i),
      .phase_neg_i  (phase_neg_i),
      .phase_sel_i  (phase_sel_i),
      .period_o     (period_o),
      .period_upd_o (period_upd_o)
   );

   task automatic chk(input bit ok, input string t, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", t, act, exp);
      end
   endtask

   task automatic model_step(input int tk, input int sb, input logic [2:0] ng, input int sl);
      int idle, chg, s, x, nxt;
      idle = (sl >= 3);
      chg  = (sl != m_sel_q);
      s    = idle ? 0 : int'(ng[sl]);
      x    = sb && m_prev_ok && m_prev_neg && !s && !chg && !idle;
      nxt  = m_cnt + ((m_armed && tk) ? 1 : 0);
      if (nxt > MAXV) nxt = MAXV;
      m_upd = x && m_armed;
      if (m_upd) m_per = nxt;
      if (chg || idle || x) m_cnt = 0;
      else m_cnt = nxt;
      if (chg || idle) m_prev_ok = 0;
      else if (sb) begin m_prev_neg = s; m_prev_ok = 1; end
      if (chg || idle) m_armed = 0;
      else if (x) m_armed = 1;
      m_sel_q = sl;
   endtask

   task automatic cyc(input logic tk, input logic sb, input logic [2:0] ng, input logic [1:0] sl);
      tick_en_i   = tk;
      smp_stb_i   = sb;
      phase_neg_i = ng;
      phase_sel_i = sl;
      @(posedge clk);
      model_step(int'(tk), int'(sb), ng, int'(sl));
      @(negedge clk);
      gcnt++;
      if (period_upd_o) begin upd_seen++; last_per = int'(period_o); end
      chk(int'(period_o) == m_per, {tag, " period"}, int'(period_o), m_per);
      chk(int'(period_upd_o) == m_upd, {tag, " pulse"}, int'(period_upd_o), m_upd);
   endtask

   task automatic wave(input int p, input int nneg, input int npos, input int reps,
                       input int tdiv, input int sdiv, input bit glitch);
      for (int r = 0; r < reps; r++) begin
         for (int i = 0; i < nneg + npos; i++) begin
            logic w;
            logic [2:0] ng;
            w = (i < nneg) || (glitch && i == nneg + 2);
            for (int k = 0; k < 3; k++) ng[k] = (k == p) ? w : ~w;
            if (p >= 3) ng = {3{w}};
            cyc((gcnt % tdiv) == 0, (i % sdiv) == 0, ng, 2'(p));
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", gcnt);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      int base;
      repeat (3) @(negedge clk);
      chk(period_o == 16'd0, "R1 reset period", int'(period_o), 0);
      chk(period_upd_o == 1'b0, "R1 reset pulse", int'(period_upd_o), 0);
      rst_n = 1'b1;

      // R4 + R2: 50 Hz line on phase A, first crossing only arms
      tag = "R4";
      wave(0, 2560, 2560, 1, 1, 1, 1'b0);
      chk(upd_seen == 0, "R4 no pulse on arming", upd_seen, 0);
      tag = "R2";
      wave(0, 2560, 2560, 1, 1, 1, 1'b0);
      chk(last_per == 5120, "R2 50Hz period", last_per, 5120);

      // R7 + R2 + R8: 60 Hz on phase B, other phases inverted
      tag = "R7";
      base = upd_seen;
      wave(1, 2133, 2134, 2, 1, 1, 1'b0);
      chk(upd_seen - base == 1, "R7 one pulse after select change", upd_seen - base, 1);
      chk(last_per == 4267, "R8 60Hz period on phase B", last_per, 4267);

      // R3: sparse strobes, glitch between strobes ignored
      tag = "R3";
      base = upd_seen;
      wave(2, 300, 300, 2, 1, 4, 1'b1);
      chk(upd_seen - base == 1, "R3 glitch ignored", upd_seen - base, 1);
      chk(last_per == 600, "R3 period with sparse strobes", last_per, 600);

      // R2: tick only on alternate cycles
      tag = "R2";
      wave(0, 200, 200, 2, 2, 1, 1'b0);
      chk(last_per == 200, "R2 alternate tick period", last_per, 200);

      // R5: very slow line saturates
      tag = "R5";
      wave(1, 10, 10, 1, 1, 1, 1'b0);
      wave(1, 66000, 10, 1, 1, 1, 1'b0);
      chk(last_per == MAXV, "R5 saturated period", last_per, MAXV);

      // R7: select change on a cycle that would be a crossing
      tag = "R7";
      wave(2, 50, 50, 1, 1, 1, 1'b0);
      cyc(1'b1, 1'b1, 3'b100, 2'd2);
      base = upd_seen;
      cyc(1'b1, 1'b1, 3'b000, 2'd0);
      cyc(1'b1, 1'b0, 3'b000, 2'd0);
      chk(upd_seen == base, "R7 crossing on change ignored", upd_seen - base, 0);
      wave(0, 50, 50, 2, 1, 1, 1'b0);
      chk(upd_seen - base == 1, "R7 full period needed", upd_seen - base, 1);
      chk(last_per == 100, "R7 period on new phase", last_per, 100);

      // R8 + R6: no phase selected, output held
      tag = "R8";
      base = upd_seen;
      wave(3, 50, 50, 3, 1, 1, 1'b0);
      chk(upd_seen == base, "R8 no pulse when idle", upd_seen - base, 0);
      chk(int'(period_o) == 100, "R6 period held", int'(period_o), 100);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   // R9: independent watch on back-to-back pulses
   logic upd_d = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (upd_d && period_upd_o) begin
            n_checks++;
            n_fail++;
            $display("FAIL R9 back-to-back pulse actual=1 expected=0");
         end
         upd_d <= period_upd_o;
      end
   end

endmodule